// File: doc/BRIEF.md
# DMA Channel Control, Status and Interrupt Register Bank

This block holds the software-visible control and status state for a bank of up to 32 DMA channel engines. Each channel owns one 32-bit word with a run control, two mode controls, live state (request pending, stopped) and three interrupt flags. Software clears these flags by writing ones. Because a flag bit reads as 1 when it is set, software can write back the word it has just read: that clears every flag it saw and leaves a running channel running. The channel engines report start, end, bus-error and stop-link events on per-channel pulse inputs. The block turns those into flags and run/stopped state.

A read-only summary word has one bit per channel. The bit is set while that channel has any interrupt pending, and the OR of all summary bits drives a single interrupt line. A handler reads the summary, services the lowest set bit first, clears that channel's flags and repeats. A further word holds one byte-alignment enable bit per channel, which goes straight to the engines. The data movement itself is outside this block.

The register port is a plain single-cycle interface. A write takes effect at the clock edge where the write enable is high. A read returns data combinationally from the current address.

Top module: `dma_irq_regbank`

## Requirements
- R1: After reset every channel word reads 0x00000008 (stopped only), the summary and alignment words read 0, and `irqOut` is low.
- R2: Channel n's word sits at byte address 4*n. Its bits are: 31 run, 30 no-descriptor-fetch mode, 29 stop-interrupt enable, 8 request pending (live copy of `reqPend[n]`, read-only), 3 stopped (read-only), 2 end flag, 1 start flag, 0 bus-error flag. All other bits read 0.
- R3: Writing a word with bit 31 set to a stopped channel sets run and clears stopped at that edge, and `chanRun[n]` goes high.
- R4: Writing a word with bit 31 clear to a channel clears run and sets stopped.
- R5: A stop-link event on a running channel clears run and sets stopped.
- R6: An event pulse sets the matching flag at the next edge. Writing 1 to a flag bit clears it, and writing 0 to a flag bit leaves it unchanged.
- R7: Writing back a value with bit 31 set to a running channel leaves it running with stopped clear, and clears every flag that was set in the written value.
- R8: When an event and a write-one-to-clear of the same flag land in the same cycle, the flag stays set.
- R9: The summary word at 0xF0 has bit n set while channel n has any flag set, or has stopped and stop-interrupt enable both set. The word is read-only, and `irqOut` is the OR of its bits.
- R10: The alignment word at 0xA0 is read/write. Its bit n drives `alignEn[n]`.
- R11: Addresses with bits [1:0] non-zero, and addresses other than the channel words, 0xA0 and 0xF0, read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Write strobe, sampled at the rising edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| evtStart | input | NUM_CH | Per-channel start event pulse |
| evtEnd | input | NUM_CH | Per-channel end event pulse |
| evtBusErr | input | NUM_CH | Per-channel bus-error event pulse |
| evtStopLink | input | NUM_CH | Per-channel halt on a stop link |
| reqPend | input | NUM_CH | Per-channel live request-pending level |
| chanRun | output | NUM_CH | Run control to each engine |
| chanNoDesc | output | NUM_CH | No-descriptor-fetch mode to each engine |
| alignEn | output | NUM_CH | Byte-alignment enable to each engine |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an engine event arriving in the very cycle that software clears the same flag. A dedicated task raises the end-event pulse and the clearing write on the same falling edge, so both meet at one rising edge. The bench then checks that the flag survived.

The second hard case is the write-back idiom on a running channel. Several flags are raised first, and the exact value read is then written back. After that write, the bench checks that the channel is still running, that the flags are gone and that the interrupt line has fallen.

// File: rtl/dmaRegBankPkg.sv
package dmaRegBankPkg;
  localparam int CH_MAX = 32;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  // channel word bit positions (software decodes these)
  localparam int CSR_RUN     = 31;
  localparam int CSR_NODESC  = 30;
  localparam int CSR_STOPIE  = 29;
  localparam int CSR_REQPEND = 8;
  localparam int CSR_STOPPED = 3;

  localparam logic [ADDR_W-1:0] ALIGN_OFS   = 8'hA0;
  localparam logic [ADDR_W-1:0] SUMMARY_OFS = 8'hF0;

  typedef enum logic [1:0] {RD_NONE, RD_CSR, RD_ALIGN, RD_SUMMARY} rdKind_e;

  typedef struct packed {
    logic [CH_MAX-1:0] csrWr;
    logic              alignWr;
    logic              runBit;
    logic              noDescBit;
    logic              stopIeBit;
    logic [2:0]        clrMask;
    logic [CH_MAX-1:0] alignBits;
    rdKind_e           rdKind;
    logic [IDX_W-1:0]  rdIdx;
  } regStrb_t;
endpackage

// File: rtl/dma_irq_regbank_ctrl.sv
module dma_irq_regbank_ctrl
  import dmaRegBankPkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output regStrb_t          strb
);
  logic             wordAligned;
  logic             csrHit;
  logic [IDX_W-1:0] chIdx;

  always_comb begin
    wordAligned = (regAddr[1:0] == 2'b00);
    chIdx       = regAddr[IDX_W+1:2];
    csrHit      = wordAligned && !regAddr[ADDR_W-1] && (int'(chIdx) < NUM_CH);

    strb           = '0;
    strb.runBit    = regWrData[CSR_RUN];
    strb.noDescBit = regWrData[CSR_NODESC];
    strb.stopIeBit = regWrData[CSR_STOPIE];
    strb.clrMask   = regWrData[2:0];
    strb.alignBits = regWrData[CH_MAX-1:0];
    strb.rdIdx     = chIdx;

    if (csrHit) begin
      strb.rdKind = RD_CSR;
      if (regWrEn) strb.csrWr[chIdx] = 1'b1;
    end else if (regAddr == ALIGN_OFS) begin
      strb.rdKind  = RD_ALIGN;
      strb.alignWr = regWrEn;
    end else if (regAddr == SUMMARY_OFS) begin
      strb.rdKind = RD_SUMMARY;
    end
  end
endmodule

// File: rtl/dma_irq_regbank_dp.sv
module dma_irq_regbank_dp
  import dmaRegBankPkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [NUM_CH-1:0] evtStart,
  input  logic [NUM_CH-1:0] evtEnd,
  input  logic [NUM_CH-1:0] evtBusErr,
  input  logic [NUM_CH-1:0] evtStopLink,
  input  logic [NUM_CH-1:0] reqPend,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CH-1:0] chanRun,
  output logic [NUM_CH-1:0] chanNoDesc,
  output logic [NUM_CH-1:0] alignEn,
  output logic              irqOut
);
  logic [NUM_CH-1:0] pendSum;
  logic [NUM_CH-1:0] alignQ;
  logic [DATA_W-1:0] csrWord [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic       runR, noDescR, stopIeR, stoppedR;
    logic       runD, stoppedD;
    logic [2:0] flagR, flagD, clrSel;

    always_comb begin
      runD     = runR;
      stoppedD = stoppedR;
      if (strb.csrWr[i]) begin
        if (!strb.runBit) begin
          runD     = 1'b0;
          stoppedD = 1'b1;
        end else if (!runR) begin
          runD     = 1'b1;
          stoppedD = 1'b0;
        end
      end
      if (runR && evtStopLink[i]) begin
        runD     = 1'b0;
        stoppedD = 1'b1;
      end
      clrSel = strb.csrWr[i] ? strb.clrMask : 3'b000;
      flagD  = (flagR & ~clrSel) | {evtEnd[i], evtStart[i], evtBusErr[i]};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runR     <= 1'b0;
        noDescR  <= 1'b0;
        stopIeR  <= 1'b0;
        stoppedR <= 1'b1;
        flagR    <= 3'b000;
      end else begin
        runR     <= runD;
        stoppedR <= stoppedD;
        flagR    <= flagD;
        if (strb.csrWr[i]) begin
          noDescR <= strb.noDescBit;
          stopIeR <= strb.stopIeBit;
        end
      end
    end

    assign csrWord[i]  = {runR, noDescR, stopIeR, 20'b0, reqPend[i], 4'b0, stoppedR, flagR};
    assign pendSum[i]  = (|flagR) | (stoppedR & stopIeR);
    assign chanRun[i]    = runR;
    assign chanNoDesc[i] = noDescR;

    // R3: a run write to a stopped channel starts it
    a_r3_start: assert property (@(posedge clk) disable iff (!rstN)
      strb.csrWr[i] && strb.runBit && !runR |=> runR && !stoppedR);
    // R4: clearing run halts the channel
    a_r4_halt: assert property (@(posedge clk) disable iff (!rstN)
      strb.csrWr[i] && !strb.runBit |=> !runR && stoppedR);
    // R5: stop link halts a running channel
    a_r5_stoplink: assert property (@(posedge clk) disable iff (!rstN)
      runR && evtStopLink[i] |=> !runR && stoppedR);
    // R7: write-back with run set keeps a running channel running
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rstN)
      strb.csrWr[i] && strb.runBit && runR && !evtStopLink[i] |=> runR && !stoppedR);
    // R8: an end event is never lost to a same-cycle clear
    a_r8_end_kept: assert property (@(posedge clk) disable iff (!rstN)
      evtEnd[i] |=> flagR[2]);
    // R9: any set flag raises the combined interrupt
    a_r9_irq: assert property (@(posedge clk) disable iff (!rstN)
      (|flagR) |-> irqOut);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alignQ <= '0;
    else if (strb.alignWr) alignQ <= strb.alignBits[NUM_CH-1:0];
  end

  assign alignEn = alignQ;
  assign irqOut  = |pendSum;

  always_comb begin
    case (strb.rdKind)
      RD_CSR:     regRdData = csrWord[strb.rdIdx];
      RD_ALIGN:   regRdData = DATA_W'(alignQ);
      RD_SUMMARY: regRdData = DATA_W'(pendSum);
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank
  import dmaRegBankPkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [NUM_CH-1:0] evtStart,
  input  logic [NUM_CH-1:0] evtEnd,
  input  logic [NUM_CH-1:0] evtBusErr,
  input  logic [NUM_CH-1:0] evtStopLink,
  input  logic [NUM_CH-1:0] reqPend,
  output logic [NUM_CH-1:0] chanRun,
  output logic [NUM_CH-1:0] chanNoDesc,
  output logic [NUM_CH-1:0] alignEn,
  output logic              irqOut
);
  regStrb_t strb;

  dma_irq_regbank_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strb     (strb)
  );

  dma_irq_regbank_dp #(.NUM_CH(NUM_CH)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .evtStart   (evtStart),
    .evtEnd     (evtEnd),
    .evtBusErr  (evtBusErr),
    .evtStopLink(evtStopLink),
    .reqPend    (reqPend),
    .regRdData  (regRdData),
    .chanRun    (chanRun),
    .chanNoDesc (chanNoDesc),
    .alignEn    (alignEn),
    .irqOut     (irqOut)
  );
endmodule

// File: tb/dma_irq_regbank_tb_top.sv
module dma_irq_regbank_tb_top;
  localparam int NCH = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [7:0]      regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic [NCH-1:0]  evtStart = '0, evtEnd = '0, evtBusErr = '0, evtStopLink = '0, reqPend = '0;
  logic [NCH-1:0]  chanRun, chanNoDesc, alignEn;
  logic            irqOut;
  int              checks = 0;
  int              fails = 0;
  bit              done = 1'b0;

  always #2.5 clk = ~clk;

  dma_irq_regbank #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtStart(evtStart),
    .evtEnd(evtEnd), .evtBusErr(evtBusErr), .evtStopLink(evtStopLink),
    .reqPend(reqPend), .chanRun(chanRun), .chanNoDesc(chanNoDesc),
    .alignEn(alignEn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chkReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  // kind: 0 start, 1 end, 2 bus error, 3 stop link
  task automatic pulse(input int kind, input logic [NCH-1:0] m);
    @(negedge clk);
    case (kind)
      0: evtStart = m;
      1: evtEnd = m;
      2: evtBusErr = m;
      default: evtStopLink = m;
    endcase
    @(negedge clk);
    evtStart = '0; evtEnd = '0; evtBusErr = '0; evtStopLink = '0;
  endtask

  task automatic t_reset();
    chkReg("R1 ch0 word", 8'h00, 32'h0000_0008);
    chkReg("R1 ch31 word", 8'h7C, 32'h0000_0008);
    chkReg("R1 summary", 8'hF0, 32'h0);
    chkReg("R1 align", 8'hA0, 32'h0);
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_start();
    wr(8'h0C, 32'h8000_0000);
    chkReg("R3 ch3 started", 8'h0C, 32'h8000_0000);
    chk("R3 chanRun", chanRun, 32'h0000_0008);
    reqPend[3] = 1'b1;
    chkReg("R2 reqPend bit8", 8'h0C, 32'h8000_0100);
    reqPend[3] = 1'b0;
  endtask

  task automatic t_modes();
    wr(8'h14, 32'h6000_0000);
    chkReg("R2 ch5 mode bits", 8'h14, 32'h6000_0008);
    chk("R2 chanNoDesc", chanNoDesc, 32'h0000_0020);
    chkReg("R9 stop irq summary", 8'hF0, 32'h0000_0020);
    chk("R9 irqOut stop", {31'b0, irqOut}, 32'h1);
    wr(8'h14, 32'h0000_0000);
    chkReg("R9 stop irq off", 8'hF0, 32'h0);
  endtask

  task automatic t_halt();
    wr(8'h0C, 32'h0000_0000);
    chkReg("R4 ch3 halted", 8'h0C, 32'h0000_0008);
    chk("R4 chanRun", chanRun, 32'h0);
  endtask

  task automatic t_stoplink();
    wr(8'h1C, 32'h8000_0000);
    chkReg("R5 ch7 running", 8'h1C, 32'h8000_0000);
    pulse(3, 32'h0000_0080);
    chkReg("R5 ch7 halted by link", 8'h1C, 32'h0000_0008);
  endtask

  task automatic t_flags();
    wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    evtStart = 32'h4; evtEnd = 32'h4; evtBusErr = 32'h4;
    @(negedge clk);
    evtStart = '0; evtEnd = '0; evtBusErr = '0;
    chkReg("R6 ch2 flags set", 8'h08, 32'h8000_0007);
    chkReg("R9 summary ch2", 8'hF0, 32'h0000_0004);
    chk("R9 irqOut", {31'b0, irqOut}, 32'h1);
    wr(8'h08, 32'h8000_0002);
    chkReg("R6 clear start only", 8'h08, 32'h8000_0005);
    wr(8'h08, 32'h8000_0005);
    chkReg("R7 write-back clears", 8'h08, 32'h8000_0000);
    chk("R7 still running", chanRun, 32'h0000_0004);
    chk("R7 irqOut low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_collide();
    pulse(1, 32'h4);
    chkReg("R8 end set", 8'h08, 32'h8000_0004);
    @(negedge clk);
    regAddr = 8'h08; regWrData = 32'h8000_0004; regWrEn = 1'b1; evtEnd = 32'h4;
    @(negedge clk);
    regWrEn = 1'b0; evtEnd = '0;
    chkReg("R8 same-cycle event kept", 8'h08, 32'h8000_0004);
    wr(8'h08, 32'h8000_0004);
    chkReg("R8 later clear", 8'h08, 32'h8000_0000);
  endtask

  task automatic t_summary();
    @(negedge clk);
    evtBusErr = 32'h0000_0002; evtStart = 32'h4000_0000;
    @(negedge clk);
    evtBusErr = '0; evtStart = '0;
    chkReg("R9 two channels", 8'hF0, 32'h4000_0002);
    wr(8'hF0, 32'hFFFF_FFFF);
    chkReg("R9 summary read-only", 8'hF0, 32'h4000_0002);
    chk("R9 irqOut two", {31'b0, irqOut}, 32'h1);
    wr(8'h04, 32'h0000_0001);
    chkReg("R9 lowest cleared", 8'hF0, 32'h4000_0000);
    wr(8'h78, 32'h0000_0002);
    chkReg("R9 all cleared", 8'hF0, 32'h0);
    chk("R9 irqOut low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_align();
    wr(8'hA0, 32'hA5A5_0F01);
    chkReg("R10 align readback", 8'hA0, 32'hA5A5_0F01);
    chk("R10 alignEn", alignEn, 32'hA5A5_0F01);
  endtask

  task automatic t_unmapped();
    wr(8'h80, 32'hFFFF_FFFF);
    chkReg("R11 hole reads 0", 8'h80, 32'h0);
    wr(8'h0D, 32'hFFFF_FFFF);
    chkReg("R11 misaligned read 0", 8'h0D, 32'h0);
    chkReg("R11 ch3 untouched", 8'h0C, 32'h0000_0008);
    chkReg("R11 align untouched", 8'hA0, 32'hA5A5_0F01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_start();
    t_modes();
    t_halt();
    t_stoplink();
    t_flags();
    t_collide();
    t_summary();
    t_align();
    t_unmapped();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule